// File: doc/BRIEF.md
# Group Address Hash Filter

This block decides whether a received frame is accepted by looking only at its 48-bit destination address. An individual address (bit 0 of the first byte clear) is accepted only when it equals a programmed 48-bit station address. A group address (bit 0 of the first byte set) is accepted when one bit of a 64-bit group table is set. The index of that bit is not a CRC. It is simply the upper six bits of the last address byte.

The table sits in two 32-bit registers, and the station address sits in two more. All four are loaded through a small write-only register port. The address arrives as one 48-bit word with a valid strobe. The decision comes out of a register one clock later.

Broadcast needs no special path. The all-ones address indexes bit 63, so broadcasts pass only while bit 31 of the high table word is set. Software normally clears the table to low word 0x00000000 and high word 0x80000000, which keeps broadcasts flowing. To accept every group address, it loads both words with 0xFFFFFFFF.

Top module: `grp_hash_filter`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `out_accept` are 0, and the table and station address are all zero. A broadcast looked up right after reset is rejected.
- R2: A write with `cfg_addr` 0 loads table bits 31..0 from `cfg_wdata`, and a write with `cfg_addr` 1 loads table bits 63..32. A write with `cfg_addr` 2 loads station address bits 31..0. A write with `cfg_addr` 3 loads station address bits 47..32 from `cfg_wdata[15:0]`.
- R3: Address byte k sits in `da[8k+7:8k]`. The table index is `da[47:42]`, which is bits 7..2 of byte 5, and bits 1..0 of byte 5 do not affect the index.
- R4: A group address (`da[0]` = 1) is accepted exactly when the table bit at its index is 1.
- R5: The all-ones broadcast address is accepted exactly when table bit 63 (bit 31 of the high word) is 1.
- R6: An individual address (`da[0]` = 0) is accepted exactly when all 48 bits equal the station address. The table has no effect on this decision.
- R7: `out_valid` is 1 in the cycle after `da_valid` is sampled high and 0 otherwise. `out_accept` is 0 whenever `out_valid` is 0.
- R8: A register write in the same cycle as a lookup does not affect that lookup. It affects the next lookup.
- R9: With both table words at 0xFFFFFFFF, every group address is accepted.
- R10: With the cleared setting (low word 0x00000000, high word 0x80000000), broadcast is accepted. A group address whose index is below 63 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 table low, 1 table high, 2 station low, 3 station high |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Destination address present |
| da | input | 48 | Destination address, byte k in bits 8k+7..8k |
| out_valid | output | 1 | Decision present, one cycle after `da_valid` |
| out_accept | output | 1 | Frame accepted |

## Verification
Group lookups are applied with a single table bit set, in turn in each half. Varying the two low bits of the last byte separates a correct index extraction from a shifted or truncated one.

The broadcast, cleared and accept-all settings are each tried. They show that bit 63 alone governs broadcast, and that the two halves are not swapped.

Individual addresses are tried against a full table, both equal and single-bit different from the station address. This shows that the table is bypassed and all 48 bits are compared.

A write that lands in the same cycle as a lookup of the bit it changes tells old-value from new-value behaviour. A long pseudo-random mix of writes, lookups and idle cycles is compared with the reference model on every clock.

// File: rtl/ghf_pkg.sv
// Shared sizing constants for the group address hash filter.
// Assumes a 48-bit destination address and a 32-bit register port.
package ghf_pkg;
    localparam int GHF_REG_W      = 32;
    localparam int GHF_TBL_BITS   = 64;
    localparam int GHF_ADDR_BYTES = 6;

    // Number of REG_W-wide words needed to hold a field of the given width.
    function automatic int words_for(input int bits, input int reg_w);
        return (bits + reg_w - 1) / reg_w;
    endfunction
endpackage

// File: rtl/ghf_cfg_regs.sv
// Configuration store: group table words followed by station address words.
// Assumes the register select numbers the table words first (lowest bits
// first), then the station address words (lowest bits first).
module ghf_cfg_regs #(
    parameter int REG_W     = 32,
    parameter int TBL_BITS  = 64,
    parameter int OWN_W     = 48,
    parameter int CFG_AW    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [TBL_BITS-1:0] tbl_q,
    output logic [OWN_W-1:0]    own_q
);
    localparam int TBL_WORDS = ghf_pkg::words_for(TBL_BITS, REG_W);
    localparam int OWN_WORDS = ghf_pkg::words_for(OWN_W, REG_W);

    // One register per table word.
    for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
        localparam logic [CFG_AW-1:0] SEL = CFG_AW'(w);
        logic [REG_W-1:0] word_q;
        // Load this table word when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (cfg_wr_en && cfg_addr == SEL)
                word_q <= cfg_wdata;
        end
        assign tbl_q[w*REG_W +: REG_W] = word_q;
    end

    // One register per station address word; the last may be narrower.
    for (genvar k = 0; k < OWN_WORDS; k++) begin : g_own
        localparam int WK = ((OWN_W - k*REG_W) < REG_W) ? (OWN_W - k*REG_W) : REG_W;
        localparam logic [CFG_AW-1:0] SEL = CFG_AW'(TBL_WORDS + k);
        logic [WK-1:0] word_q;
        // Load this station address word when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (cfg_wr_en && cfg_addr == SEL)
                word_q <= cfg_wdata[WK-1:0];
        end
        assign own_q[k*REG_W +: WK] = word_q;
    end
endmodule

// File: rtl/ghf_addr_class.sv
// Classifies a destination address: group flag from bit 0 of the first
// byte, table index from the top bits of the last byte.
// Purely combinational; assumes byte k lives in bits 8k+7..8k.
module ghf_addr_class #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] da,
    output logic              is_group,
    output logic [IDX_W-1:0]  idx
);
    // Extract the group flag and the table index.
    always_comb begin
        is_group = da[0];
        idx      = da[ADDR_W-1 -: IDX_W];
    end
endmodule

// File: rtl/ghf_decide.sv
// Accept decision and its output register. Reads the table and the station
// address as they stand before the clock edge, so a same-cycle write is
// seen only by later lookups.
module ghf_decide #(
    parameter int ADDR_W   = 48,
    parameter int TBL_BITS = 64,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                da_valid,
    input  logic [ADDR_W-1:0]   da,
    input  logic                is_group,
    input  logic [IDX_W-1:0]    idx,
    input  logic [TBL_BITS-1:0] tbl_q,
    input  logic [ADDR_W-1:0]   own_q,
    output logic                out_valid,
    output logic                out_accept
);
    logic hit;

    // Group: table bit lookup; individual: exact station address match.
    always_comb begin
        if (is_group)
            hit = tbl_q[idx];
        else
            hit = (da == own_q);
    end

    // Register the decision, qualified by the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
        end else begin
            out_valid  <= da_valid;
            out_accept <= da_valid & hit;
        end
    end
endmodule

// File: rtl/grp_hash_filter.sv
// Top of the group address hash filter: register store, address
// classification and registered accept decision, one cycle of latency.
module grp_hash_filter #(
    parameter int REG_W      = ghf_pkg::GHF_REG_W,
    parameter int TBL_BITS   = ghf_pkg::GHF_TBL_BITS,
    parameter int ADDR_BYTES = ghf_pkg::GHF_ADDR_BYTES,
    localparam int ADDR_W    = ADDR_BYTES * 8,
    localparam int IDX_W     = $clog2(TBL_BITS),
    localparam int CFG_AW    = $clog2(ghf_pkg::words_for(TBL_BITS, REG_W)
                                      + ghf_pkg::words_for(ADDR_W, REG_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    output logic              out_valid,
    output logic              out_accept
);
    logic [TBL_BITS-1:0] tbl_q;
    logic [ADDR_W-1:0]   own_q;
    logic                is_group;
    logic [IDX_W-1:0]    idx;

    ghf_cfg_regs #(
        .REG_W(REG_W), .TBL_BITS(TBL_BITS), .OWN_W(ADDR_W), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tbl_q(tbl_q), .own_q(own_q)
    );

    ghf_addr_class #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_class (
        .da(da), .is_group(is_group), .idx(idx)
    );

    ghf_decide #(.ADDR_W(ADDR_W), .TBL_BITS(TBL_BITS), .IDX_W(IDX_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
        .is_group(is_group), .idx(idx), .tbl_q(tbl_q), .own_q(own_q),
        .out_valid(out_valid), .out_accept(out_accept)
    );
endmodule

// File: rtl/ghf_checker.sv
// Protocol and decision checks for grp_hash_filter, bound to the top.
module ghf_checker #(
    parameter int ADDR_W   = 48,
    parameter int TBL_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                da_valid,
    input logic [ADDR_W-1:0]   da,
    input logic [TBL_BITS-1:0] tbl,
    input logic [ADDR_W-1:0]   own,
    input logic                out_valid,
    input logic                out_accept
);
    localparam int IDX_W = $clog2(TBL_BITS);

    // R1: reset forces the output strobe low on the next cycle
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R7: decision appears exactly one cycle after the address strobe
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(da_valid));

    // R7: accept is never raised without valid
    p_accept_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_accept);

    // R4: group lookups follow the selected table bit
    p_group_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da[0]) |=> out_accept == $past(tbl[da[ADDR_W-1 -: IDX_W]]));

    // R5: broadcast follows the top table bit
    p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && &da) |=> out_accept == $past(tbl[TBL_BITS-1]));

    // R6: individual addresses need an exact station match
    p_unicast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !da[0]) |=> out_accept == $past(da == own));
endmodule

bind grp_hash_filter ghf_checker #(.ADDR_W(ADDR_W), .TBL_BITS(TBL_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da), .tbl(tbl_q),
    .own(own_q), .out_valid(out_valid), .out_accept(out_accept)
);

// File: tb/sim_grp_hash_filter.sv
module sim_grp_hash_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        out_valid, out_accept;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // Reference state
    logic [63:0] m_tbl = '0;
    logic [47:0] m_own = '0;
    logic [31:0] lfsr = 32'h1ACE_2B3D;

    localparam logic [47:0] OWN  = 48'h665544332210; // byte0 = 0x10, individual
    localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;

    always #2 clk = ~clk; // 250 MHz

    grp_hash_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .out_valid(out_valid), .out_accept(out_accept)
    );

    function automatic logic [47:0] grp(input logic [7:0] b5);
        return {b5, 32'h5E00_A7C3, 8'h01};
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One clock: drive at negedge, predict, then compare at the next negedge.
    task automatic step(input bit wr, input logic [1:0] a, input logic [31:0] d,
                        input bit dv, input logic [47:0] addr, input string tag);
        logic ev, ea;
        cfg_wr_en = wr; cfg_addr = a; cfg_wdata = d; da_valid = dv; da = addr;
        if (!rst_n) begin
            ev = 0; ea = 0;
        end else begin
            ev = dv;
            if (addr[0]) ea = dv && m_tbl[addr[47:42]];
            else         ea = dv && (addr == m_own);
            if (wr) begin
                case (a)
                    2'd0: m_tbl[31:0]  = d;
                    2'd1: m_tbl[63:32] = d;
                    2'd2: m_own[31:0]  = d;
                    default: m_own[47:32] = d[15:0];
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        vectors++;
        if (out_valid !== ev || out_accept !== ea) begin
            miscompares++;
            $display("FAIL %s: valid/accept got %b/%b expected %b/%b (da=%h)",
                     tag, out_valid, out_accept, ev, ea, addr);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        step(1, a, d, 0, '0, tag);
    endtask

    task automatic look(input logic [47:0] addr, input string tag);
        step(0, 2'd0, '0, 1, addr, tag);
    endtask

    initial begin
        @(negedge clk);
        // R1: outputs quiet during reset even with a strobe
        step(0, 0, 0, 1, BCST, "R1");
        step(0, 0, 0, 0, '0, "R1");
        rst_n = 1'b1;
        look(BCST, "R1");            // empty table rejects broadcast
        look(grp(8'h00), "R1");
        step(0, 0, 0, 0, '0, "R7");  // idle cycle: valid low

        // R2 / R3: single bit in each half
        wr(2'd0, 32'h0000_0001, "R2");
        look(grp(8'h00), "R2");      // index 0
        look(grp(8'h03), "R3");      // low two bits ignored
        look(grp(8'h04), "R3");      // index 1 rejected
        wr(2'd1, 32'h0000_0001, "R2");
        look(grp(8'h80), "R2");      // index 32
        look(grp(8'h83), "R3");
        look(grp(8'h7C), "R3");      // index 31 clear

        // R5 / R10: cleared setting
        wr(2'd0, 32'h0, "R10");
        wr(2'd1, 32'h8000_0000, "R10");
        look(BCST, "R5");
        look(grp(8'hFC), "R5");
        look(grp(8'hF8), "R10");
        look(grp(8'h00), "R10");
        wr(2'd1, 32'h7FFF_FFFF, "R5");
        look(BCST, "R5");            // rejected
        look(grp(8'hF8), "R4");      // index 62 accepted

        // R9: accept all
        wr(2'd0, 32'hFFFF_FFFF, "R9");
        wr(2'd1, 32'hFFFF_FFFF, "R9");
        for (int i = 0; i < 64; i++) look(grp(8'(i << 2)), "R9");

        // R6: individual addresses ignore the full table
        look(OWN, "R6");             // no station address yet
        wr(2'd2, OWN[31:0], "R2");
        wr(2'd3, {16'hDEAD, OWN[47:32]}, "R2");
        look(OWN, "R6");
        look(OWN ^ 48'h8000_0000_0000, "R6");
        look(OWN ^ 48'h0000_0000_0100, "R6");
        look(OWN ^ 48'h0001_0000_0000, "R6");

        // R8: write coinciding with lookup of the bit it changes
        wr(2'd0, 32'h0000_0000, "R8");
        step(1, 2'd0, 32'h0000_0004, 1, grp(8'h08), "R8"); // old value: reject
        look(grp(8'h08), "R8");                             // new value: accept
        step(1, 2'd0, 32'h0, 1, grp(8'h08), "R8");          // old value: accept
        look(grp(8'h08), "R8");                             // reject
        step(1, 2'd2, 32'h0, 1, OWN, "R8");                 // old station: accept
        look(OWN, "R8");                                    // changed: reject

        // R4 / R7: pseudo-random mix, back-to-back and idle
        for (int n = 0; n < 2000; n++) begin
            logic [47:0] a48;
            lfsr = nxt(lfsr);
            a48 = {lfsr[31:16], nxt(lfsr)};
            if (lfsr[3:0] == 4'd0)      a48 = BCST;
            else if (lfsr[3:0] == 4'd1) a48 = m_own;
            step(lfsr[7:5] == 3'd0, lfsr[9:8], nxt(nxt(lfsr)), lfsr[11:10] != 2'd0,
                 a48, a48[0] ? "R4" : "R6");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule